// File: doc/BRIEF.md
# Multi-Format Serial PCM Audio Receiver

This block receives two-channel PCM audio over a three-wire serial link: a bit clock, a frame clock that separates the channels, and one data line. It runs on the system clock. It samples the three wires and passes them through a synchronizer, then acts on each rising bit-clock edge it detects. A 2-bit format field selects one of four framings at run time. A 2-bit word-length field sets the sample size, and only the right-justified framing uses it.

For every complete frame the block presents one left and one right sample. Each sample is a signed value sign-extended to 24 bits, and a one-cycle valid strobe marks it. Configuration comes from a control word input and is latched only at a frame start, so a frame is never assembled from two configurations. When the new framing sees a frame start in the middle of the current frame, the frame in progress is dropped and produces no strobe.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset the valid strobe is low and both sample outputs are zero.
- R2: Control bits [3:2] select the framing: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified. Bits [1:0] give the word length: 00 is 24 bits, 01 is 20 bits, 10 and 11 are 16 bits. All other control bits have no effect on the outputs.
- R3: In I2S framing the left channel is sent while the frame clock is low. Data is sampled on bit-clock rising edges. The MSB is the second bit after a frame-clock transition, and 24 bits are taken MSB first.
- R4: In left-justified framing the left channel is sent while the frame clock is high. The MSB is the first bit after the transition, and 24 bits are taken MSB first.
- R5: In right-justified framing the left channel is sent while the frame clock is high. The LSB is the last bit of each 32-bit half-frame, and the MSB lies word-length bits before the end of that half-frame. The captured value is sign-extended to 24 bits.
- R6: In DSP framing a one-bit-wide high pulse on the frame clock starts the frame. The left MSB is the next bit, and the 24 right bits follow the left LSB with no gap.
- R7: Outside right-justified framing the word-length field has no effect, and samples are always 24 bits.
- R8: After both channels of a frame are captured, the valid strobe is high for exactly one system cycle. It rises 4 system cycles after the bit-clock rising edge that carried the last right bit. The samples stay unchanged until the next strobe.
- R9: A control change made during a frame takes effect at the next frame start. The frame in progress is decoded with the old settings.
- R10: When a format change makes the new framing detect a frame start partway through a frame, the interrupted frame produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | CTRL_W | Control word: format in [3:2], word length in [1:0] |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame / channel-select clock |
| sdata_i | input | 1 | Serial audio data |
| smp_valid_o | output | 1 | One-cycle strobe when a sample pair is ready |
| smp_left_o | output | SAMPLE_W | Left sample, signed, sign-extended |
| smp_right_o | output | SAMPLE_W | Right sample, signed, sign-extended |

## Verification
The strobe and its sample pair appear at the fourth system clock edge after the rising bit-clock edge that carries the right LSB. That edge is the synchronizer's two stages, the framer and lane registers, and the output register. The bench records the cycle of that bit-clock edge and the cycle in which it sees the strobe, and checks that the gap is exactly 4. It compares sample values and strobe counts only after the whole frame has been sent plus a settling gap, so early or duplicate strobes are counted rather than missed. Cases where a frame must be dropped are observed over the full frame and the same settling gap. The held outputs are then compared against the previous pair.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_DSP = 2'b10,
        FMT_LJ  = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wlen;
    } rx_cfg_t;

    localparam int FMT_LSB  = 2;
    localparam int WLEN_LSB = 0;

    function automatic rx_cfg_t decode_ctrl(input logic [3:0] low_bits);
        rx_cfg_t c;
        c.fmt  = fmt_e'(low_bits[FMT_LSB +: 2]);
        c.wlen = low_bits[WLEN_LSB +: 2];
        return c;
    endfunction

    function automatic int wlen_bits(input logic [1:0] wl);
        case (wl)
            2'b00:   return 24;
            2'b01:   return 20;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/psr_pin_sync.sv
module psr_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lr_i,
    input  logic dat_i,
    output logic rise_o,
    output logic lr_o,
    output logic dat_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] stage_d [SYNC_STAGES];
    logic [2:0] stage_q [SYNC_STAGES];
    logic       bclk_prev_d, bclk_prev_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = {bclk_i, lr_i, dat_i};
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    always_comb bclk_prev_d = stage_q[LAST][2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_prev_d;
    end

    assign rise_o = stage_q[LAST][2] & ~bclk_prev_q;
    assign lr_o   = stage_q[LAST][1];
    assign dat_o  = stage_q[LAST][0];

    // a detected edge is a single-cycle event
    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3

endmodule

// File: rtl/psr_framer.sv
module psr_framer
    import psr_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int POS_TOP   = 2 * SLOT_BITS,
    parameter int POS_W     = $clog2(POS_TOP + 1),
    parameter int LEN_W     = $clog2(SAMPLE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             lr_i,
    input  rx_cfg_t          ctrl_cfg_i,
    output rx_cfg_t          cfg_o,
    output logic             start_o,
    output logic             cap_left_o,
    output logic             cap_right_o,
    output logic             last_o,
    output logic [LEN_W-1:0] len_o
);
    typedef struct packed {
        rx_cfg_t          cfg;
        logic             lr_prev;
        logic             seen;
        logic             run;
        logic             right;
        logic [POS_W-1:0] pos;
    } fr_state_t;

    fr_state_t        st_d, st_q;
    logic             start_c, cap_c, last_c, chan_c;
    logic [POS_W-1:0] len_c, first_c;

    function automatic logic frame_edge(input fmt_e f, input logic p, input logic c);
        return (f == FMT_I2S) ? (p & ~c) : (~p & c);
    endfunction

    always_comb begin
        st_d    = st_q;
        start_c = 1'b0;
        cap_c   = 1'b0;
        last_c  = 1'b0;
        chan_c  = 1'b0;
        len_c   = '0;
        first_c = '0;
        if (evt_i) begin
            st_d.lr_prev = lr_i;
            st_d.seen    = 1'b1;
            start_c = st_q.seen && frame_edge(ctrl_cfg_i.fmt, st_q.lr_prev, lr_i);
            if (start_c) begin
                st_d.cfg   = ctrl_cfg_i;
                st_d.pos   = '0;
                st_d.right = 1'b0;
                st_d.run   = 1'b1;
            end else if (st_q.run) begin
                if (st_q.cfg.fmt != FMT_DSP && lr_i != st_q.lr_prev) begin
                    if (!st_q.right) begin
                        st_d.right = 1'b1;
                        st_d.pos   = '0;
                    end else begin
                        st_d.run = 1'b0;
                    end
                end else if (st_q.pos != POS_W'(POS_TOP)) begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end

            len_c = (st_d.cfg.fmt == FMT_RJ) ? POS_W'(wlen_bits(st_d.cfg.wlen))
                                             : POS_W'(SAMPLE_W);
            case (st_d.cfg.fmt)
                FMT_I2S: begin
                    chan_c  = st_d.right;
                    first_c = POS_W'(1);
                end
                FMT_LJ: begin
                    chan_c  = st_d.right;
                    first_c = '0;
                end
                FMT_RJ: begin
                    chan_c  = st_d.right;
                    first_c = POS_W'(SLOT_BITS) - len_c;
                end
                default: begin
                    chan_c  = (st_d.pos > len_c);
                    first_c = chan_c ? len_c + POS_W'(1) : POS_W'(1);
                end
            endcase

            if (st_d.run && st_d.pos >= first_c && st_d.pos < first_c + len_c) begin
                cap_c  = 1'b1;
                last_c = (st_d.pos == first_c + len_c - POS_W'(1));
                if (last_c && chan_c) st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o       = st_q.cfg;
    assign start_o     = start_c;
    assign cap_left_o  = cap_c & ~chan_c;
    assign cap_right_o = cap_c & chan_c;
    assign last_o      = last_c;
    assign len_o       = len_c[LEN_W-1:0];

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg != $past(st_q.cfg)) |-> $past(start_o)); // R9

    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_W'(POS_TOP)); // R6

endmodule

// File: rtl/psr_lane.sv
module psr_lane #(
    parameter int SAMPLE_W = 24,
    parameter int LEN_W    = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                shift_i,
    input  logic                bit_i,
    input  logic                last_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                done_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [LEN_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] sample;
        logic                done;
    } lane_state_t;

    lane_state_t         st_d, st_q;
    logic [SAMPLE_W-1:0] base_sh;
    logic [LEN_W-1:0]    base_cnt;

    function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw,
                                                 input logic [LEN_W-1:0] len);
        logic [SAMPLE_W-1:0] r;
        logic [LEN_W-1:0]    top;
        top = len - LEN_W'(1);
        for (int i = 0; i < SAMPLE_W; i++) begin
            r[i] = (LEN_W'(i) < len) ? raw[i] : raw[top];
        end
        return r;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        base_sh   = clear_i ? '0 : st_q.shreg;
        base_cnt  = clear_i ? '0 : st_q.cnt;
        st_d.shreg = base_sh;
        st_d.cnt   = base_cnt;
        if (shift_i) begin
            st_d.shreg = {base_sh[SAMPLE_W-2:0], bit_i};
            st_d.cnt   = base_cnt + 1'b1;
            if (last_i) begin
                st_d.sample = sext(st_d.shreg, len_i);
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign done_o   = st_q.done;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LEN_W'(SAMPLE_W)); // R5

    // the framer's last-bit mark must coincide with a full-length word in this lane
    AST_LAST_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && last_i) |-> (st_d.cnt == len_i)); // R8

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import psr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_BITS   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    output logic                smp_valid_o,
    output logic [SAMPLE_W-1:0] smp_left_o,
    output logic [SAMPLE_W-1:0] smp_right_o
);
    localparam int LEN_W = $clog2(SAMPLE_W + 1);

    typedef struct packed {
        logic                left_have;
        logic                valid;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } top_state_t;

    top_state_t          st_d, st_q;
    rx_cfg_t             ctrl_cfg, act_cfg;
    logic                evt, lr_s, dat_s, start;
    logic                cap_l, cap_r, cap_last;
    logic [LEN_W-1:0]    cap_len;
    logic [SAMPLE_W-1:0] left_smp, right_smp;
    logic                left_done, right_done;
    logic                ctrl_unused;

    assign ctrl_cfg    = decode_ctrl(ctrl_i[3:0]);
    assign ctrl_unused = ^ctrl_i[CTRL_W-1:4];

    psr_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk_i(bclk_i),
        .lr_i  (lrclk_i),
        .dat_i (sdata_i),
        .rise_o(evt),
        .lr_o  (lr_s),
        .dat_o (dat_s)
    );

    psr_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .lr_i       (lr_s),
        .ctrl_cfg_i (ctrl_cfg),
        .cfg_o      (act_cfg),
        .start_o    (start),
        .cap_left_o (cap_l),
        .cap_right_o(cap_r),
        .last_o     (cap_last),
        .len_o      (cap_len)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_lane
        logic                shift_c, done_c;
        logic [SAMPLE_W-1:0] smp_c;
        assign shift_c = (ch == 0) ? cap_l : cap_r;
        psr_lane #(.SAMPLE_W(SAMPLE_W)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start),
            .shift_i (shift_c),
            .bit_i   (dat_s),
            .last_i  (cap_last),
            .len_i   (cap_len),
            .sample_o(smp_c),
            .done_o  (done_c)
        );
        if (ch == 0) begin : g_l
            assign left_smp  = smp_c;
            assign left_done = done_c;
        end else begin : g_r
            assign right_smp  = smp_c;
            assign right_done = done_c;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = right_done && st_q.left_have;
        if (left_done)          st_d.left_have = 1'b1;
        if (start || st_d.valid) st_d.left_have = 1'b0;
        if (st_d.valid) begin
            st_d.left  = left_smp;
            st_d.right = right_smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_valid_o = st_q.valid;
    assign smp_left_o  = st_q.left;
    assign smp_right_o = st_q.right;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> ($stable(smp_left_o) && $stable(smp_right_o))); // R8

    AST_RJ16_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && act_cfg.fmt == FMT_RJ && act_cfg.wlen[1])
        |-> (smp_left_o[SAMPLE_W-1:15] == {(SAMPLE_W-15){smp_left_o[15]}})); // R5

endmodule

// File: tb/pcm_serial_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_rx_tb_top;
    localparam int SLOT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl = '0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic        smp_valid;
    logic [23:0] smp_left, smp_right;

    int checks = 0, fails = 0, cyc = 0;
    int got_cnt = 0, got_cyc = 0, last_rise = 0;
    logic [23:0] got_l = '0, got_r = '0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .bclk_i(bclk), .lrclk_i(lrclk),
        .sdata_i(sdata), .smp_valid_o(smp_valid), .smp_left_o(smp_left), .smp_right_o(smp_right)
    );

    always @(negedge clk) begin
        if (smp_valid) begin
            got_cnt++;
            got_l   = smp_left;
            got_r   = smp_right;
            got_cyc = cyc;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] wl);
        return (wl == 2'b00) ? 24 : (wl == 2'b01) ? 20 : 16;
    endfunction

    function automatic logic [23:0] expect_smp(input logic [1:0] fmt, input logic [1:0] wl,
                                               input logic [23:0] raw);
        logic [23:0] r;
        int w;
        if (fmt != 2'b01) return raw;
        w = wbits(wl);
        for (int i = 0; i < 24; i++) r[i] = (i < w) ? raw[i] : raw[w-1];
        return r;
    endfunction

    function automatic string fmt_req(input logic [1:0] fmt);
        case (fmt)
            2'b00:   return "R3";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic send_bit(input logic lr, input logic d, input bit mark);
        @(negedge clk);
        bclk = 1'b0; lrclk = lr; sdata = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        if (mark) last_rise = cyc;
        repeat (3) @(negedge clk);
    endtask

    task automatic prime(input logic [1:0] fmt);
        for (int i = 0; i < SLOT; i++) send_bit(fmt == 2'b00, 1'($urandom), 1'b0);
    endtask

    task automatic send_frame(input logic [1:0] fmt, input logic [1:0] wl,
                              input logic [23:0] l, input logic [23:0] r,
                              input int chg_at, input logic [10:0] chg_ctrl);
        int last_idx;
        case (fmt)
            2'b00:   last_idx = SLOT + 24;
            2'b11:   last_idx = SLOT + 23;
            2'b01:   last_idx = 2 * SLOT - 1;
            default: last_idx = 48;
        endcase
        for (int i = 0; i < 2 * SLOT; i++) begin
            int half, p, w;
            logic [23:0] v;
            logic lr, d;
            half = i / SLOT;
            p    = i % SLOT;
            v    = (half != 0) ? r : l;
            w    = wbits(wl);
            d    = 1'($urandom);
            case (fmt)
                2'b00: begin lr = (half != 0); if (p >= 1 && p <= 24) d = v[24-p]; end
                2'b11: begin lr = (half == 0); if (p < 24) d = v[23-p]; end
                2'b01: begin lr = (half == 0); if (p >= SLOT - w) d = v[SLOT-1-p]; end
                default: begin
                    lr = (i == 0);
                    if (i >= 1 && i <= 24)       d = l[24-i];
                    else if (i >= 25 && i <= 48) d = r[48-i];
                end
            endcase
            if (i == chg_at) ctrl = chg_ctrl;
            send_bit(lr, d, i == last_idx);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic verify_frame(input string req, input logic [1:0] fmt, input logic [1:0] wl,
                                input logic [23:0] l, input logic [23:0] r);
        check(req, "strobe count (R8)", got_cnt, 1);
        check(req, "left", int'(got_l), int'(expect_smp(fmt, wl, l)));
        check(req, "right", int'(got_r), int'(expect_smp(fmt, wl, r)));
        check("R8", "strobe latency", got_cyc - last_rise, 4);
        check("R8", "left held", int'(smp_left), int'(got_l));
    endtask

    task automatic run_case(input string req, input logic [1:0] fmt, input logic [1:0] wl,
                            input logic [10:0] cw, input logic [23:0] l, input logic [23:0] r);
        ctrl = cw;
        prime(fmt);
        got_cnt = 0;
        send_frame(fmt, wl, l, r, -1, cw);
        verify_frame(req, fmt, wl, l, r);
    endtask

    initial begin
        logic [23:0] held_l;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "valid after reset", int'(smp_valid), 0);
        check("R1", "left after reset", int'(smp_left), 0);
        check("R1", "right after reset", int'(smp_right), 0);

        run_case("R3", 2'b00, 2'b00, 11'h000, 24'h800001, 24'h7FFFFE);
        run_case("R7", 2'b00, 2'b10, 11'h002, 24'hA5C3F0, 24'h0F1E2D);
        run_case("R4", 2'b11, 2'b00, 11'h00C, 24'hFFFFFF, 24'h123456);
        run_case("R7", 2'b11, 2'b01, 11'h00D, 24'h8F0001, 24'h400000);
        run_case("R5", 2'b01, 2'b00, 11'h004, 24'h876543, 24'h000001);
        run_case("R5", 2'b01, 2'b01, 11'h005, 24'h0C0001, 24'h07FFFF);
        run_case("R5", 2'b01, 2'b10, 11'h006, 24'h008000, 24'hFF7FFF);
        run_case("R5", 2'b01, 2'b11, 11'h007, 24'h12F00F, 24'h340123);
        run_case("R6", 2'b10, 2'b00, 11'h008, 24'h800000, 24'h7FFFFF);
        run_case("R2", 2'b11, 2'b00, 11'h7FC | 11'h00C, 24'h5A5A5A, 24'hC3C3C3);
        run_case("R2", 2'b01, 2'b10, 11'h7F6, 24'h00ABCD, 24'h009876);

        // R9: word length changed mid-frame applies only from the next frame
        ctrl = 11'h004;
        prime(2'b01);
        got_cnt = 0;
        send_frame(2'b01, 2'b00, 24'h9ABCDE, 24'h1357BD, 10, 11'h006);
        verify_frame("R9", 2'b01, 2'b00, 24'h9ABCDE, 24'h1357BD);
        got_cnt = 0;
        send_frame(2'b01, 2'b10, 24'h00F123, 24'h0070AB, -1, 11'h006);
        verify_frame("R9", 2'b01, 2'b10, 24'h00F123, 24'h0070AB);

        // R10: a format change that finds a new frame start drops the frame in flight
        ctrl = 11'h00C;
        prime(2'b11);
        got_cnt = 0;
        held_l = smp_left;
        send_frame(2'b11, 2'b00, 24'h111111, 24'h222222, 5, 11'h000);
        check("R10", "strobes for dropped frame", got_cnt, 0);
        check("R10", "outputs held (R8)", int'(smp_left), int'(held_l));

        for (int k = 0; k < 30; k++) begin
            logic [1:0]  fmt, wl;
            logic [10:0] cw;
            fmt = 2'($urandom);
            wl  = 2'($urandom);
            cw  = 11'($urandom);
            cw[3:0] = {fmt, wl};
            run_case(fmt_req(fmt), fmt, wl, cw, 24'($urandom), 24'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule